// File: doc/BRIEF.md
# Bit-Serial Carry-State Adder

This block adds two unsigned numbers that arrive one bit position per clock, lowest position first. On each cycle that carries a pair, the caller drives one bit of each operand together with a pair strobe. The block returns that position's sum bit in the same cycle. Its only stored state is the running carry, which is one of two states: carry clear or carry set.

Each incoming pair is sorted into one of three kinds. Both bits high is a generate and sets the carry. Both bits low is a kill and clears it. Mixed bits are a propagate and keep the carry as it is. The sum bit depends on the transition taken, so the outputs are Mealy outputs.

A caller starts an operand either with a synchronous clear followed by its pairs, or by raising a first-pair strobe on the lowest pair. It marks the highest pair with a last flag. The operand width is set only by how many pairs are streamed. The final carry-out is captured when the last pair is taken and stays on the output until the next clear or the next first pair.

Top module: `sadd_serial_adder`

## Requirements
- R1: After reset, `sum_valid`, `done` and `carry_out` are 0, and the stored carry is 0. A first pair sent without `first` therefore sums as if no carry were present.
- R2: When `sum_valid` is 1, `sum_bit` equals `a_bit` XOR `b_bit` XOR the incoming carry, in the same cycle as the pair. When `sum_valid` is 0, `sum_bit` is 0.
- R3: An accepted pair with both bits 1 (generate) leaves the stored carry at 1.
- R4: An accepted pair with both bits 0 (kill) leaves the stored carry at 0.
- R5: An accepted pair with one bit 1 and one bit 0 (propagate) leaves the incoming carry unchanged.
- R6: A pair accepted with `first` high uses an incoming carry of 0, whatever carry is stored.
- R7: On a cycle with `pair_valid` low, the stored carry does not change.
- R8: `sum_valid` is 1 exactly when `pair_valid` is 1 and `clr` is 0.
- R9: `clr` has priority. It makes the stored carry 0 and drives `done` and `carry_out` to 0 from the next cycle. A pair presented in the same cycle is discarded.
- R10: An accepted pair with `last` high makes `done` 1 and makes `carry_out` equal to that pair's outgoing carry from the next cycle. Both then hold until a `clr`, or until a pair accepted with `first` high and `last` low, which returns them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of the carry and the result |
| pair_valid | input | 1 | A bit pair is present this cycle |
| first | input | 1 | This pair is the lowest position of a new operand |
| last | input | 1 | This pair is the highest position of the operand |
| a_bit | input | 1 | Bit of operand A |
| b_bit | input | 1 | Bit of operand B |
| sum_bit | output | 1 | Sum bit for the present pair |
| sum_valid | output | 1 | `sum_bit` is meaningful |
| carry_out | output | 1 | Final carry of the last finished operand |
| done | output | 1 | `carry_out` holds a finished result |

## Verification
Three pairs of functions can fall in the same cycle. The first is the opening and the closing of an operand: a one-bit operand raises `first` and `last` together. The bench sends such operands and checks that the sum ignores the stored carry while `carry_out` takes the carry produced by that single pair. The second is a clear that arrives with a valid last pair. The bench checks that the pair yields no sum and no result, and that the next pair sent without `first` sees a carry of 0. The third is a gap between pairs: random idle cycles are mixed into operands of random width and random data. Every sum bit and every final carry is compared with arithmetic addition computed in the bench.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  // Kind of one bit pair with respect to the carry it leaves behind.
  typedef enum logic [1:0] {
    PAIR_KILL = 2'd0,
    PAIR_PROP = 2'd1,
    PAIR_GEN  = 2'd2
  } pair_kind_e;

  // The two states of the serial adder.
  typedef enum logic {
    CY_CLEAR = 1'b0,
    CY_SET   = 1'b1
  } carry_state_e;

endpackage

// File: rtl/sadd_rst_sync.sv
module sadd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  localparam int LAST_IDX = STAGES - 1;

  logic [LAST_IDX:0] chain_q;
  logic [LAST_IDX:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST_IDX-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[LAST_IDX];

endmodule

// File: rtl/sadd_pair_class.sv
module sadd_pair_class
  import sadd_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       carry_in,
  input  logic       take,
  output pair_kind_e kind,
  output logic       sum_bit
);

  // Sort the pair into generate, kill or propagate.
  always_comb begin
    unique case ({a_bit, b_bit})
      2'b11:   kind = PAIR_GEN;
      2'b00:   kind = PAIR_KILL;
      default: kind = PAIR_PROP;
    endcase
  end

  // Mealy output: the sum depends on the transition taken.
  always_comb begin
    sum_bit = 1'b0;
    if (take) begin
      unique case (kind)
        PAIR_PROP: sum_bit = ~carry_in;
        default:   sum_bit = carry_in;
      endcase
    end
  end

endmodule

// File: rtl/sadd_carry_fsm.sv
module sadd_carry_fsm
  import sadd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  logic       first,
  input  pair_kind_e kind,
  output logic       carry_in,
  output logic       carry_next,
  output logic       carry_q
);

  carry_state_e state_q;
  carry_state_e state_d;
  carry_state_e after_pair;
  logic         load_en;

  // A first pair ignores whatever carry is stored.
  always_comb carry_in = first ? 1'b0 : (state_q == CY_SET);

  always_comb begin
    unique case (kind)
      PAIR_GEN:  after_pair = CY_SET;
      PAIR_KILL: after_pair = CY_CLEAR;
      default:   after_pair = carry_in ? CY_SET : CY_CLEAR;
    endcase
  end

  always_comb begin
    load_en = clr | take;
    state_d = state_q;
    if (clr)       state_d = CY_CLEAR;
    else if (take) state_d = after_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= CY_CLEAR;
    else if (load_en) state_q <= state_d;
  end

  assign carry_next = (after_pair == CY_SET);
  assign carry_q    = (state_q == CY_SET);

endmodule

// File: rtl/sadd_result.sv
module sadd_result (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic first,
  input  logic last,
  input  logic carry_next,
  output logic done,
  output logic carry_out
);

  logic done_d;
  logic cout_d;
  logic res_en;

  always_comb begin
    res_en = clr | (take & (last | first));
    done_d = done;
    cout_d = carry_out;
    if (clr) begin
      done_d = 1'b0;
      cout_d = 1'b0;
    end else if (take && last) begin
      done_d = 1'b1;
      cout_d = carry_next;
    end else if (take && first) begin
      done_d = 1'b0;
      cout_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      carry_out <= 1'b0;
    end else if (res_en) begin
      done      <= done_d;
      carry_out <= cout_d;
    end
  end

endmodule

// File: rtl/sadd_serial_adder.sv
module sadd_serial_adder
  import sadd_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pair_valid,
  input  logic first,
  input  logic last,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic sum_valid,
  output logic carry_out,
  output logic done
);

  logic       rst_ns;
  logic       take;
  logic       carry_in;
  logic       carry_next;
  logic       carry_q;
  pair_kind_e kind;

  sadd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // A clear in the same cycle discards the pair.
  assign take      = pair_valid & ~clr;
  assign sum_valid = take;

  sadd_pair_class u_class (
    .a_bit    (a_bit),
    .b_bit    (b_bit),
    .carry_in (carry_in),
    .take     (take),
    .kind     (kind),
    .sum_bit  (sum_bit)
  );

  sadd_carry_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_ns),
    .clr        (clr),
    .take       (take),
    .first      (first),
    .kind       (kind),
    .carry_in   (carry_in),
    .carry_next (carry_next),
    .carry_q    (carry_q)
  );

  sadd_result u_res (
    .clk        (clk),
    .rst_n      (rst_ns),
    .clr        (clr),
    .take       (take),
    .first      (first),
    .last       (last),
    .carry_next (carry_next),
    .done       (done),
    .carry_out  (carry_out)
  );

endmodule

// File: rtl/sadd_checker.sv
module sadd_checker (
  input logic clk,
  input logic rst_ns,
  input logic clr,
  input logic pair_valid,
  input logic first,
  input logic last,
  input logic a_bit,
  input logic b_bit,
  input logic carry_q,
  input logic sum_bit,
  input logic sum_valid,
  input logic done,
  input logic carry_out
);

  a_r3_generate_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    (pair_valid && !clr && a_bit && b_bit) |=> carry_q);

  a_r4_kill_clears: assert property (@(posedge clk) disable iff (!rst_ns)
    (pair_valid && !clr && !a_bit && !b_bit) |=> !carry_q);

  a_r5_propagate_keeps: assert property (@(posedge clk) disable iff (!rst_ns)
    (pair_valid && !clr && !first && (a_bit != b_bit)) |=> (carry_q == $past(carry_q)));

  a_r6_first_mixed_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    (pair_valid && !clr && first && (a_bit != b_bit)) |=> !carry_q);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_ns)
    (!pair_valid && !clr) |=> $stable(carry_q));

  a_r8_no_sum_when_idle: assert property (@(posedge clk) disable iff (!rst_ns)
    (!pair_valid || clr) |-> (!sum_valid && !sum_bit));

  a_r9_clear_result: assert property (@(posedge clk) disable iff (!rst_ns)
    clr |=> (!carry_q && !done && !carry_out));

  a_r10_last_sets_done: assert property (@(posedge clk) disable iff (!rst_ns)
    (pair_valid && !clr && last) |=> (done && (carry_out == carry_q)));

  a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_ns)
    (!clr && !(pair_valid && (first || last))) |=> ($stable(carry_out) && $stable(done)));

endmodule

bind sadd_serial_adder sadd_checker u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .clr        (clr),
  .pair_valid (pair_valid),
  .first      (first),
  .last       (last),
  .a_bit      (a_bit),
  .b_bit      (b_bit),
  .carry_q    (carry_q),
  .sum_bit    (sum_bit),
  .sum_valid  (sum_valid),
  .done       (done),
  .carry_out  (carry_out)
);

// File: tb/sim_sadd_serial_adder.sv
`timescale 1ns/1ps
module sim_sadd_serial_adder;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, clr, pair_valid, first, last, a_bit, b_bit;
  wire  sum_bit, sum_valid, carry_out, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model of the requirements
  logic m_carry, m_done, m_cout;

  sadd_serial_adder u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pair_valid(pair_valid),
    .first(first), .last(last), .a_bit(a_bit), .b_bit(b_bit),
    .sum_bit(sum_bit), .sum_valid(sum_valid), .carry_out(carry_out), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic next_carry(input logic a, input logic b, input logic ci);
    return (a & b) | ((a ^ b) & ci);
  endfunction

  // One cycle: check held result, drive pair, check sum, update model.
  task automatic step(input logic a, input logic b, input logic st, input logic ls,
                      input logic cl, input logic vl, input string rq, output logic sb);
    logic ci;
    logic nc;
    @(negedge clk);
    chk({rq, " R10 carry_out held"}, carry_out, m_cout);
    chk({rq, " R10 done held"}, done, m_done);
    a_bit = a; b_bit = b; first = st; last = ls; clr = cl; pair_valid = vl;
    #1;
    ci = st ? 1'b0 : m_carry;
    chk({rq, " R8 sum_valid"}, sum_valid, vl & ~cl);
    chk({rq, " R2 sum_bit"}, sum_bit, (vl & ~cl) ? (a ^ b ^ ci) : 1'b0);
    sb = sum_bit;
    if (cl) begin
      m_carry = 1'b0; m_done = 1'b0; m_cout = 1'b0;
    end else if (vl) begin
      nc = next_carry(a, b, ci);
      m_carry = nc;
      if (ls) begin
        m_done = 1'b1; m_cout = nc;
      end else if (st) begin
        m_done = 1'b0; m_cout = 1'b0;
      end
    end
  endtask

  task automatic random_operand(input int w, input int idle_pct);
    logic [63:0] a, b, got, exp;
    logic sb;
    a = {$urandom, $urandom};
    b = {$urandom, $urandom};
    got = '0;
    for (int i = 0; i < w; i++) begin
      while (($urandom % 100) < idle_pct)
        step($urandom, $urandom, $urandom, $urandom, 1'b0, 1'b0, "R7 gap", sb);
      step(a[i], b[i], i == 0, i == w - 1, 1'b0, 1'b1, "R3 R4 R5 stream", sb);
      got[i] = sb;
    end
    exp = (a & ((64'd1 << w) - 1)) + (b & ((64'd1 << w) - 1));
    chk("R2 operand sum", got, exp & ((64'd1 << w) - 1));
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 after", sb);
    chk("R10 final carry", carry_out, exp[w]);
  endtask

  initial begin
    logic sb;
    void'($urandom(32'd7919));
    rst_n = 1'b0; clr = 1'b0; pair_valid = 1'b0; first = 1'b0; last = 1'b0;
    a_bit = 1'b0; b_bit = 1'b0;
    m_carry = 1'b0; m_done = 1'b0; m_cout = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset sum_valid", sum_valid, 1'b0);
    chk("R1 reset done", done, 1'b0);
    chk("R1 reset carry_out", carry_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: stored carry is clear, mixed pair without first sums to 1
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1 first pair", sb);
    // R3 generate, R5 propagate of a set carry, R4 kill
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3 generate", sb);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5 propagate set", sb);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 propagate set", sb);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 kill", sb);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5 propagate clear", sb);
    // R6: first overrides a set carry
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3 set", sb);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6 first ignores carry", sb);
    // R7: idle cycles with live data keep the carry
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3 set", sb);
    for (int k = 0; k < 4; k++)
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 idle", sb);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 carry kept", sb);
    // R10: one-bit operand with first and last together
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 one-bit", sb);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 hold", sb);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 one-bit mixed", sb);
    // R9: clear together with a valid last pair
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10 set result", sb);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R9 clear wins", sb);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 carry cleared", sb);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 after", sb);

    // random operands, width 1..63, with gaps
    for (int n = 0; n < 300; n++)
      random_operand(1 + ($urandom % 63), (n % 3) * 15);
    random_operand(63, 0);
    random_operand(1, 0);

    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 end", sb);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule